// File: doc/BRIEF.md
# Programmable Periodic Pulse Generator

The block produces a single-clock pulse at a programmable period expressed in nanoseconds of timer time. A 32-bit accumulator adds a frequency addend to itself on every system clock while the block is enabled. Each carry out of its top bit is one timer tick, so the addend sets the nominal tick rate. The tick spacing can vary by one clock.

A down counter starts from a programmed interval. On every tick it loses a programmed step, which is the nominal tick period in nanoseconds. When a tick brings the counter to zero or below, the pulse output is raised for one clock and the counter stops at zero. The next tick reloads the interval. One full period therefore lasts interval plus one step nanoseconds. To get a period of P ns, software programs P minus the step. For one pulse per second with a 5 ns step, that is 999999995.

The three settings are written through a small write port. While enable is low the accumulator is held at zero and the counter follows the interval register. The first period after enable therefore ends one tick earlier than later periods.

Top module: `ppg_top`

## Requirements
- R1: While enabled, the accumulator adds the addend every clock and each carry out of bit 31 is a timer tick. With addend 0x80000000 a tick occurs every second clock, and with 0x40000000 every fourth clock.
- R2: On a tick with no reload pending, a counter greater than the step is reduced by the step. With step 10, interval 95 and ticks every second clock, the first pulse comes 20 clocks after enable and later pulses are 22 clocks apart.
- R3: A pulse is raised in the clock after a tick that finds the counter at or below the step. The pulse is high for exactly one clock.
- R4: The tick that follows a pulse reloads the counter from the interval register and does not decrement. With step 5, interval 95 and addend 0x80000000, the first pulse is 38 clocks after enable and later pulses are 40 clocks apart. With interval 0 they are 4 clocks apart.
- R5: A tick that would take the counter below zero saturates it at zero and fires the pulse. With interval 97, step 5 and addend 0x80000000, pulses are 42 clocks apart.
- R6: An interval written while enabled does not change the period in progress. It is used from the next reload on.
- R7: While enable is low, the accumulator is zero, the counter equals the interval, no reload is pending and the pulse output is low. The first period after enable starts from the interval.
- R8: During reset the pulse output is low and all settings and state are zero. Reset is asserted asynchronously and released on a clock edge.
- R9: A write with cfg_addr 0 sets the addend, 1 sets the step and 2 sets the interval. Address 3 is ignored. A setting written at one edge is used from the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the accumulator cleared and the counter loaded |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting select: 0 addend, 1 step, 2 interval |
| cfg_wdata | input | 32 | Setting write data |
| pulse_o | output | 1 | One-clock periodic pulse |

## Verification
The bound checker checks these on every clock: the accumulator sum, the decrement by the step, the saturating fire, the one-clock pulse width, the reload on the tick after a pulse, and the held state while disabled. Whole-period properties span many ticks, so only the bench scenarios can show them: the interval-plus-one-step spacing, the shorter first period, a mid-period interval write that only takes hold at the next reload, and an ignored write to the unused address. A behavioural model in the bench tracks nanoseconds remaining and compares the pulse output every clock.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    CFG_ADDEND   = 2'd0,
    CFG_STEP     = 2'd1,
    CFG_INTERVAL = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/ppg_cfg_regs.sv
module ppg_cfg_regs
  import ppg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addend,
  output logic [DW-1:0] step,
  output logic [DW-1:0] interval
);
  logic [DW-1:0] addend_d, step_d, interval_d;

  always_comb begin
    addend_d   = addend;
    step_d     = step;
    interval_d = interval;
    if (we) begin
      case (cfg_sel_e'(addr))
        CFG_ADDEND:   addend_d   = wdata;
        CFG_STEP:     step_d     = wdata;
        CFG_INTERVAL: interval_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addend   <= '0;
      step     <= '0;
      interval <= '0;
    end else begin
      addend   <= addend_d;
      step     <= step_d;
      interval <= interval_d;
    end
  end
endmodule

// File: rtl/ppg_tick_acc.sv
module ppg_tick_acc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] addend,
  output logic [DW-1:0] acc,
  output logic          tick
);
  logic [DW:0]   sum;
  logic [DW-1:0] acc_d;

  always_comb begin
    sum   = {1'b0, acc} + {1'b0, addend};
    tick  = en & sum[DW];
    acc_d = en ? sum[DW-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_d;
  end
endmodule

// File: rtl/ppg_down_cnt.sv
module ppg_down_cnt #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] interval,
  output logic [DW-1:0] cnt,
  output logic          pend,
  output logic          pulse
);
  logic [DW-1:0] cnt_d;
  logic          pend_d, pulse_d;

  always_comb begin
    cnt_d   = cnt;
    pend_d  = pend;
    pulse_d = 1'b0;
    if (!en) begin
      cnt_d  = interval;
      pend_d = 1'b0;
    end else if (tick) begin
      if (pend) begin
        cnt_d  = interval;
        pend_d = 1'b0;
      end else if (cnt <= step) begin
        cnt_d   = '0;
        pend_d  = 1'b1;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt - step;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= 1'b0;
      pulse <= 1'b0;
    end else begin
      cnt   <= cnt_d;
      pend  <= pend_d;
      pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/ppg_top.sv
module ppg_top #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          pulse_o
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [DW-1:0]          addend, step, interval, acc, cnt;
  logic                   tick, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  ppg_cfg_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .addend(addend), .step(step), .interval(interval)
  );

  ppg_tick_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .addend(addend),
    .acc(acc), .tick(tick)
  );

  ppg_down_cnt #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .tick(tick), .step(step),
    .interval(interval), .cnt(cnt), .pend(pend), .pulse(pulse_o)
  );
endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tick,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] addend,
  input logic [DW-1:0] cnt,
  input logic          pend,
  input logic [DW-1:0] step,
  input logic [DW-1:0] interval,
  input logic          pulse_o
);
  // R1
  acc_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> acc == $past(acc + addend));
  // R2
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !pend && cnt > step) |=> (cnt == $past(cnt - step)) && !pulse_o);
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);
  // R3
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(en && tick && !pend));
  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && pend) |=> (cnt == $past(interval)) && !pend && !pulse_o);
  // R5
  sat_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !pend && cnt <= step) |=> (cnt == '0) && pulse_o && pend);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0) && (cnt == $past(interval)) && !pend && !pulse_o);
endmodule

bind ppg_top ppg_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(en), .tick(tick), .acc(acc),
  .addend(addend), .cnt(cnt), .pend(pend), .step(step),
  .interval(interval), .pulse_o(pulse_o)
);

// File: tb/ppg_top_tb.sv
module ppg_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        pulse_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ppg_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pulse_o(pulse_o)
  );

  // Behavioural model: remaining nanoseconds, a phase accumulator as a wide integer
  longint unsigned m_phase, m_add, m_step, m_int, m_left;
  bit m_reload, m_pulse;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_add = 0; m_step = 0; m_int = 0; m_left = 0;
      m_reload = 0; m_pulse = 0;
    end else begin
      longint unsigned nxt;
      nxt = m_phase + m_add;
      m_pulse = 0;
      if (!en) begin
        m_phase = 0; m_left = m_int; m_reload = 0;
      end else begin
        m_phase = nxt % (64'd1 << 32);
        if (nxt >= (64'd1 << 32)) begin
          if (m_reload) begin
            m_left = m_int; m_reload = 0;
          end else if (m_left <= m_step) begin
            m_left = 0; m_reload = 1; m_pulse = 1;
          end else begin
            m_left = m_left - m_step;
          end
        end
      end
      if (cfg_we) begin
        if (cfg_addr == 2'd0) m_add = cfg_wdata;
        else if (cfg_addr == 2'd1) m_step = cfg_wdata;
        else if (cfg_addr == 2'd2) m_int = cfg_wdata;
      end
    end
  end

  // Per-clock comparison (R3, R4 model)
  always @(negedge clk) begin
    if (!finished) begin
      compared++;
      if (pulse_o !== m_pulse) begin
        mismatched++;
        $display("FAIL R3 model pulse_o at %0t: actual %0b expected %0b", $time, pulse_o, m_pulse);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en = v;
  endtask

  // Cycles from now until the next pulse is seen
  task automatic gap(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!pulse_o && n < 1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R8 pulse low in reset", int'(pulse_o), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 pulse low after reset", int'(pulse_o), 0);

    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd95);
    set_en(1'b1);
    gap(n); chk("R4 first period 95/5", n, 38);
    gap(n); chk("R4 period 95/5", n, 40);

    // R6: mid-period interval write
    repeat (4) @(negedge clk);
    wr(2'd2, 32'd97);
    gap(n); chk("R6 period in progress kept", n, 35);
    gap(n); chk("R5 saturating period 97/5", n, 42);
    gap(n); chk("R5 saturating period repeat", n, 42);

    // R7: disable
    set_en(1'b0);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      chk("R7 no pulse while disabled", int'(pulse_o), 0);
    end
    wr(2'd2, 32'd95);
    wr(2'd0, 32'h4000_0000);
    set_en(1'b1);
    gap(n); chk("R1 first period slow tick", n, 76);
    gap(n); chk("R1 period slow tick", n, 80);

    // R2: larger step
    set_en(1'b0);
    wr(2'd0, 32'h8000_0000);
    wr(2'd1, 32'd10);
    set_en(1'b1);
    gap(n); chk("R2 first period step 10", n, 20);
    gap(n); chk("R2 period step 10", n, 22);

    // R4 interval 0
    set_en(1'b0);
    wr(2'd1, 32'd5);
    wr(2'd2, 32'd0);
    set_en(1'b1);
    gap(n); chk("R4 first pulse interval 0", n, 2);
    gap(n); chk("R4 period interval 0", n, 4);

    // R9: unused address ignored
    wr(2'd3, 32'd0);
    gap(n);
    gap(n); chk("R9 address 3 ignored", n, 4);

    // Fast ticking addend, model comparison only
    set_en(1'b0);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd2, 32'd20);
    set_en(1'b1);
    repeat (60) @(negedge clk);

    // R8: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 pulse low on reset", int'(pulse_o), 0);
    repeat (3) @(negedge clk);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 pulse low after release", int'(pulse_o), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule